// File: doc/BRIEF.md
# SPI Host Interrupt Status and Mask Unit

This unit collects the interrupt sources of a SPI host controller that moves bytes through a transmit FIFO and a receive FIFO. It produces one level-sensitive interrupt line. Three sources are error events that arrive as one-cycle pulses: transmit underflow, receive overflow and mode fault. Each of them is latched until software acknowledges it. Four sources are FIFO level conditions. They are recomputed every clock from the FIFO occupancy counts and full flags, and two of them are compared against thresholds that software programs.

Software reaches the unit through a small word-addressed register port. The mask is never written directly. One register adds bits to the mask and another removes them, so two agents can enable and disable different sources without a read-modify-write race. The interrupt output is registered.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the mask, every status bit and the interrupt output are 0, both thresholds read back as 1, and the read data register holds 0.
- R2: Status bit positions are: bit 0 receive overflow, bit 1 mode fault, bit 2 transmit below threshold, bit 3 transmit full, bit 4 receive at or above threshold, bit 5 receive full, bit 6 transmit underflow. Bits above 6 read as 0.
- R3: Bits 0, 1 and 6 are set by their event pulse and stay set until software writes 1 to that bit of the status register (address 0). Writing 0 leaves a bit unchanged.
- R4: When an event pulse and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 4 is 1 exactly when the receive count was at least the receive threshold (address 5) at the previous clock edge.
- R6: Status bit 2 is 1 exactly when the transmit count was below the transmit threshold (address 4) at the previous edge. Bits 3 and 5 copy the transmit-full and receive-full flags, also with one cycle of delay.
- R7: A write to address 1 ORs the written bits 6:0 into the mask. A write to address 2 clears the written bits from the mask. A write to the mask address 3 has no effect on the mask.
- R8: Reads of addresses 1 and 2 return 0. Reads of address 3 return the mask.
- R9: The interrupt output equals the OR of (mask AND status) as it stood one cycle earlier.
- R10: Writing 1 to status bits 2 to 5 has no effect, so these bits keep following the FIFO state.
- R11: The threshold registers at addresses 4 and 5 hold the low bits of the written value, as many bits as are needed to count 0 through the FIFO depth. A read returns the register contents one cycle after the read strobe. Unused addresses 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| tx_full | input | 1 | Transmit FIFO full flag |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_full | input | 1 | Receive FIFO full flag |
| ev_tx_underflow | input | 1 | One-cycle transmit underflow event |
| ev_rx_overflow | input | 1 | One-cycle receive overflow event |
| ev_mode_fault | input | 1 | One-cycle mode fault event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The assertions assume that the FIFO counts never exceed the FIFO depth and that each full flag is high only when its count equals the depth. They make no assumption about how event pulses line up with register writes, so an event and a clear can land in the same cycle. The random stimulus draws counts only from 0 through the depth and derives each full flag from its count. It also fires events and register accesses independently, so collisions between them happen regularly.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int ST_W = 7;
  localparam int B_RX_OVF   = 0;
  localparam int B_MODE_F   = 1;
  localparam int B_TX_BELOW = 2;
  localparam int B_TX_FULL  = 3;
  localparam int B_RX_AT    = 4;
  localparam int B_RX_FULL  = 5;
  localparam int B_TX_UNF   = 6;
  localparam int N_EVT      = 3;

  typedef enum logic [2:0] {
    RA_STATUS = 3'd0,
    RA_M_SET  = 3'd1,
    RA_M_CLR  = 3'd2,
    RA_MASK   = 3'd3,
    RA_TX_THR = 3'd4,
    RA_RX_THR = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q_o[i] <= 1'b0;
      else     q_o[i] <= (q_o[i] & ~clr_i[i]) | set_i[i];
    end
  end
endmodule

// File: rtl/spi_irq_level.sv
module spi_irq_level #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             tx_full,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_full,
  input  logic [CNT_W-1:0] tx_thr,
  input  logic [CNT_W-1:0] rx_thr,
  output logic             tx_below_o,
  output logic             tx_full_o,
  output logic             rx_at_o,
  output logic             rx_full_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_below_o <= 1'b0;
      tx_full_o  <= 1'b0;
      rx_at_o    <= 1'b0;
      rx_full_o  <= 1'b0;
    end else begin
      tx_below_o <= tx_count < tx_thr;
      tx_full_o  <= tx_full;
      rx_at_o    <= rx_count >= rx_thr;
      rx_full_o  <= rx_full;
    end
  end
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ST_W-1:0]   status_i,
  output logic [ST_W-1:0]   mask_o,
  output logic [ST_W-1:0]   w1c_o,
  output logic [CNT_W-1:0]  tx_thr_o,
  output logic [CNT_W-1:0]  rx_thr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [CNT_W-1:0] THR_RST = CNT_W'(1);

  logic [ST_W-1:0]   wbits;
  logic [DATA_W-1:0] rd_mux;

  assign wbits = wdata[ST_W-1:0];
  assign w1c_o = (wr && addr == ADDR_W'(RA_STATUS)) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o   <= '0;
      tx_thr_o <= THR_RST;
      rx_thr_o <= THR_RST;
    end else if (wr) begin
      if (addr == ADDR_W'(RA_M_SET))  mask_o   <= mask_o | wbits;
      if (addr == ADDR_W'(RA_M_CLR))  mask_o   <= mask_o & ~wbits;
      if (addr == ADDR_W'(RA_TX_THR)) tx_thr_o <= wdata[CNT_W-1:0];
      if (addr == ADDR_W'(RA_RX_THR)) rx_thr_o <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(RA_STATUS))      rd_mux = DATA_W'(status_i);
    else if (addr == ADDR_W'(RA_MASK))   rd_mux = DATA_W'(mask_o);
    else if (addr == ADDR_W'(RA_TX_THR)) rd_mux = DATA_W'(tx_thr_o);
    else if (addr == ADDR_W'(RA_RX_THR)) rd_mux = DATA_W'(rx_thr_o);
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_o <= '0;
    else if (rd) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 32,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              tx_full,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_full,
  input  logic              ev_tx_underflow,
  input  logic              ev_rx_overflow,
  input  logic              ev_mode_fault,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [ST_W-1:0]  status_w;
  logic [ST_W-1:0]  mask_w;
  logic [ST_W-1:0]  w1c_w;
  logic [CNT_W-1:0] tx_thr_w;
  logic [CNT_W-1:0] rx_thr_w;
  logic [N_EVT-1:0] evt_set;
  logic [N_EVT-1:0] evt_clr;
  logic [N_EVT-1:0] evt_q;
  logic tx_below, tx_full_q, rx_at, rx_full_q;

  assign evt_set = {ev_tx_underflow, ev_mode_fault, ev_rx_overflow};
  assign evt_clr = {w1c_w[B_TX_UNF], w1c_w[B_MODE_F], w1c_w[B_RX_OVF]};

  spi_irq_sticky #(.N(N_EVT)) u_sticky (
    .clk(clk), .rst(rst), .set_i(evt_set), .clr_i(evt_clr), .q_o(evt_q)
  );

  spi_irq_level #(.CNT_W(CNT_W)) u_level (
    .clk(clk), .rst(rst),
    .tx_count(tx_count), .tx_full(tx_full),
    .rx_count(rx_count), .rx_full(rx_full),
    .tx_thr(tx_thr_w), .rx_thr(rx_thr_w),
    .tx_below_o(tx_below), .tx_full_o(tx_full_q),
    .rx_at_o(rx_at), .rx_full_o(rx_full_q)
  );

  always_comb begin
    status_w             = '0;
    status_w[B_RX_OVF]   = evt_q[0];
    status_w[B_MODE_F]   = evt_q[1];
    status_w[B_TX_UNF]   = evt_q[2];
    status_w[B_TX_BELOW] = tx_below;
    status_w[B_TX_FULL]  = tx_full_q;
    status_w[B_RX_AT]    = rx_at;
    status_w[B_RX_FULL]  = rx_full_q;
  end

  spi_irq_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .status_i(status_w), .mask_o(mask_w),
    .w1c_o(w1c_w), .tx_thr_o(tx_thr_w), .rx_thr_o(rx_thr_w),
    .rdata_o(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(mask_w & status_w);
  end
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk
  import spi_irq_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_tx_underflow,
  input logic              ev_rx_overflow,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [2:0]        w1c,
  input logic [ST_W-1:0]   status,
  input logic [ST_W-1:0]   mask,
  input logic [CNT_W-1:0]  tx_count,
  input logic [CNT_W-1:0]  rx_count,
  input logic [CNT_W-1:0]  tx_thr,
  input logic [CNT_W-1:0]  rx_thr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq
);
  logic st_wr;
  assign st_wr = reg_wr && reg_addr == ADDR_W'(RA_STATUS);

  a_r3_overflow_holds: assert property (@(posedge clk) disable iff (rst)
    (status[B_RX_OVF] && !(st_wr && w1c[0])) |=> status[B_RX_OVF]);
  a_r3_modefault_holds: assert property (@(posedge clk) disable iff (rst)
    (status[B_MODE_F] && !(st_wr && w1c[1])) |=> status[B_MODE_F]);
  a_r4_overflow_set_wins: assert property (@(posedge clk) disable iff (rst)
    ev_rx_overflow |=> status[B_RX_OVF]);
  a_r4_underflow_set_wins: assert property (@(posedge clk) disable iff (rst)
    ev_tx_underflow |=> status[B_TX_UNF]);
  a_r5_rx_level: assert property (@(posedge clk) disable iff (rst)
    (rx_count >= rx_thr) |=> status[B_RX_AT]);
  a_r5_rx_below: assert property (@(posedge clk) disable iff (rst)
    (rx_count < rx_thr) |=> !status[B_RX_AT]);
  a_r6_tx_level: assert property (@(posedge clk) disable iff (rst)
    (tx_count < tx_thr) |=> status[B_TX_BELOW]);
  a_r7_mask_direct: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(RA_MASK)) |=> $stable(mask));
  a_r8_set_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(RA_M_SET)) |=> reg_rdata == '0);
  a_r9_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|(mask & status)) |=> irq);
  a_r9_irq_low: assert property (@(posedge clk) disable iff (rst)
    !(|(mask & status)) |=> !irq);
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst),
  .ev_tx_underflow(ev_tx_underflow), .ev_rx_overflow(ev_rx_overflow),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .w1c({reg_wdata[6], reg_wdata[1], reg_wdata[0]}),
  .status(status_w), .mask(mask_w),
  .tx_count(tx_count), .rx_count(rx_count),
  .tx_thr(tx_thr_w), .rx_thr(rx_thr_w),
  .reg_rdata(reg_rdata), .irq(irq)
);

// File: tb/test_spi_irq_ctrl.sv
module test_spi_irq_ctrl;
  localparam int DEPTH = 32;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int AW    = 3;
  localparam int DW    = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [CW-1:0] tx_count = '0, rx_count = '0;
  logic tx_full = 1'b0, rx_full = 1'b0;
  logic ev_unf = 1'b0, ev_ovf = 1'b0, ev_mf = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq;

  spi_irq_ctrl #(.FIFO_DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) i_spi_irq_ctrl (
    .clk(clk), .rst(rst), .tx_count(tx_count), .tx_full(tx_full),
    .rx_count(rx_count), .rx_full(rx_full), .ev_tx_underflow(ev_unf),
    .ev_rx_overflow(ev_ovf), .ev_mode_fault(ev_mf), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  int checks = 0, failures = 0;

  // bench model of the register state
  logic [6:0]    m_mask = '0, m_sticky = '0, m_level = '0;
  logic [CW-1:0] m_txthr = CW'(1), m_rxthr = CW'(1);
  logic          m_irq = 1'b0;
  logic [DW-1:0] m_rdata = '0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] level_of(input logic [CW-1:0] tc, input logic tf,
      input logic [CW-1:0] rc, input logic rf, input logic [CW-1:0] tt, input logic [CW-1:0] rt);
    logic [6:0] v = '0;
    v[2] = tc < tt;
    v[3] = tf;
    v[4] = rc >= rt;
    v[5] = rf;
    return v;
  endfunction

  function automatic logic [DW-1:0] read_of(input logic [AW-1:0] a);
    case (a)
      3'd0: return DW'(m_sticky | m_level);
      3'd3: return DW'(m_mask);
      3'd4: return DW'(m_txthr);
      3'd5: return DW'(m_rxthr);
      default: return '0;
    endcase
  endfunction

  // one clock: inputs already driven at the falling edge
  task automatic step(input string tag);
    logic [6:0] clr, setv;
    logic nirq;
    logic [6:0] nlvl;
    nirq = |(m_mask & (m_sticky | m_level));
    nlvl = level_of(tx_count, tx_full, rx_count, rx_full, m_txthr, m_rxthr);
    if (reg_rd) m_rdata = read_of(reg_addr);
    clr  = (reg_wr && reg_addr == 3'd0) ? reg_wdata[6:0] : '0;
    setv = {ev_unf, 4'b0, ev_mf, ev_ovf};
    m_sticky = ((m_sticky & ~clr) | setv) & 7'b1000011;
    if (reg_wr && reg_addr == 3'd1) m_mask = m_mask | reg_wdata[6:0];
    if (reg_wr && reg_addr == 3'd2) m_mask = m_mask & ~reg_wdata[6:0];
    if (reg_wr && reg_addr == 3'd4) m_txthr = reg_wdata[CW-1:0];
    if (reg_wr && reg_addr == 3'd5) m_rxthr = reg_wdata[CW-1:0];
    m_level = nlvl;
    m_irq = nirq;
    @(negedge clk);
    chk("R9 irq", DW'(irq), DW'(m_irq));
    if (reg_rd) chk(tag, reg_rdata, m_rdata);
    reg_wr = 1'b0; reg_rd = 1'b0; ev_unf = 1'b0; ev_ovf = 1'b0; ev_mf = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step("write");
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    step(tag);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq after reset", DW'(irq), '0);
    rd(3'd3, "R1 mask");            chk("R1 mask zero", reg_rdata, '0);
    rd(3'd4, "R1 tx threshold");    chk("R1 tx threshold one", reg_rdata, 32'd1);
    rd(3'd5, "R1 rx threshold");    chk("R1 rx threshold one", reg_rdata, 32'd1);
    // R7 mask access
    wr(3'd3, 32'h7F);
    rd(3'd3, "R7 direct write ignored"); chk("R7 mask unchanged", reg_rdata, '0);
    wr(3'd1, 32'h11);
    rd(3'd3, "R7 set");             chk("R7 set ors", reg_rdata, 32'h11);
    wr(3'd2, 32'h01);
    rd(3'd3, "R7 clear");           chk("R7 clear bits", reg_rdata, 32'h10);
    // R8
    rd(3'd1, "R8 set reads zero");  chk("R8 set zero", reg_rdata, '0);
    rd(3'd2, "R8 clr reads zero");  chk("R8 clr zero", reg_rdata, '0);
    // R11 threshold and unused addresses
    wr(3'd6, 32'hFFFF);
    rd(3'd6, "R11 unused reads zero"); chk("R11 unused", reg_rdata, '0);
    wr(3'd5, 32'hFFFF_FF04);
    rd(3'd5, "R11 rx threshold");   chk("R11 rx thr low bits", reg_rdata, 32'd4);
    // R5 boundary
    rx_count = CW'(3); step("idle");
    rd(3'd0, "R5 below");           chk("R5 count3 thr4", DW'(reg_rdata[4]), '0);
    rx_count = CW'(4); step("idle");
    rd(3'd0, "R5 at");              chk("R5 count4 thr4", DW'(reg_rdata[4]), 32'd1);
    chk("R9 masked level raises irq", DW'(irq), 32'd1);
    // R6 boundary
    tx_count = CW'(1); step("idle");
    rd(3'd0, "R6 at thr");          chk("R6 tx count1 thr1", DW'(reg_rdata[2]), '0);
    tx_count = CW'(0); tx_full = 1'b1; step("idle");
    rd(3'd0, "R6 below");           chk("R6 tx below", DW'(reg_rdata[2]), 32'd1);
    chk("R6 tx full", DW'(reg_rdata[3]), 32'd1);
    tx_full = 1'b0;
    // R3 / R4 sticky
    ev_ovf = 1'b1; step("idle");
    repeat (3) step("idle");
    rd(3'd0, "R3 held");            chk("R3 overflow held", DW'(reg_rdata[0]), 32'd1);
    ev_ovf = 1'b1; wr(3'd0, 32'h1);
    rd(3'd0, "R4 set wins");        chk("R4 set beats clear", DW'(reg_rdata[0]), 32'd1);
    wr(3'd0, 32'h0);
    rd(3'd0, "R3 zero write");      chk("R3 zero keeps", DW'(reg_rdata[0]), 32'd1);
    wr(3'd0, 32'h1);
    rd(3'd0, "R3 cleared");         chk("R3 w1c clears", DW'(reg_rdata[0]), '0);
    ev_mf = 1'b1; ev_unf = 1'b1; step("idle");
    rd(3'd0, "R2 event bits");      chk("R2 mode fault and underflow", reg_rdata & 32'h43, 32'h42);
    // R10 level bits ignore w1c
    wr(3'd0, 32'h3C);
    rd(3'd0, "R10 level unchanged"); chk("R10 rx level kept", DW'(reg_rdata[4]), 32'd1);
    // R9 disable drops irq after one cycle
    wr(3'd2, 32'h7F);
    step("idle");
    chk("R9 irq low after disable", DW'(irq), '0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int op;
      tx_count = CW'($urandom_range(0, DEPTH));
      rx_count = CW'($urandom_range(0, DEPTH));
      tx_full  = (tx_count == CW'(DEPTH));
      rx_full  = (rx_count == CW'(DEPTH));
      ev_ovf   = ($urandom % 12) == 0;
      ev_unf   = ($urandom % 12) == 0;
      ev_mf    = ($urandom % 12) == 0;
      op = $urandom % 8;
      reg_addr  = AW'($urandom % 8);
      reg_wdata = (reg_addr >= 3'd4) ? DW'($urandom_range(0, DEPTH)) : DW'($urandom);
      reg_wr = (op < 2);
      reg_rd = (op >= 2 && op < 5);
      step("R2 R3 R5 R6 R7 R11 random read");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule